// File: doc/BRIEF.md
# Programmable Periodic Interrupt Rate Generator

The block turns a 32768 Hz time base, given as a one-cycle tick enable on the system clock, into a periodic event pulse. A 4-bit rate code selects a power-of-two period. A separate enable gates the output. The pulse is one system clock wide and goes to an interrupt flag register outside this block.

A free-running counter counts every tick from reset, whether or not the generator is enabled. An event fires on the tick that brings the counter's low bits to zero. Because of this, events fall on fixed period boundaries of the tick count, not at a time measured from when the generator was enabled. The rate code and enable are sampled on every tick, so a change takes effect at the next tick without restarting anything.

Top module: `prr_rate_gen`

## Requirements
- R1: After reset, evt_o is low and the tick count is zero, so with code 3 enabled from reset the first event follows the fourth tick.
- R2: evt_o rises only in the clock cycle after an edge that sampled tick_i high, and it is never high in two consecutive cycles.
- R3: With rate_i equal to 0, evt_o stays low.
- R4: With en_i low, evt_o stays low, but the tick count keeps advancing on every tick.
- R5: For rate_i from 3 to 15, the period is 2^(rate_i-1) ticks: code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R6: Rate codes 1 and 2 behave as codes 8 and 9, giving periods of 128 and 256 ticks.
- R7: An event fires on the tick that makes the tick count since reset, modulo 32768, a multiple of the period. This holds no matter when en_i was raised.
- R8: A change of rate_i or en_i applies from the next tick onward, with no restart of the count.
- R9: The 15-bit tick count wraps from 32767 to 0, and that wrap fires an event for every active code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe at 32768 Hz |
| rate_i | input | 4 | Rate code; 0 turns the generator off |
| en_i | input | 1 | Periodic event enable |
| evt_o | output | 1 | One-cycle periodic event pulse |

## Verification
The bench uses the default parameters: a 15-bit count, a 4-bit code, and aliasing of codes 1 and 2 by +7. In the directed phases, tick_i is held high on every cycle. This makes the longest period of 16384 ticks, and a full wrap of the count, reachable within the cycle budget. Random phases with sparse ticks and frequent code and enable changes then test alignment, gating, and the next-tick effect of a change.

// File: rtl/prr_pkg.sv
package prr_pkg;
  localparam int unsigned SHIFT_W = 8;

  // Maps a rate code to log2 of its period, folding the low alias codes upward.
  function automatic logic [SHIFT_W-1:0] rate_shift(input logic [SHIFT_W-1:0] code,
                                                    input logic [SHIFT_W-1:0] alias_last,
                                                    input logic [SHIFT_W-1:0] alias_ofs);
    logic [SHIFT_W-1:0] c;
    c = (code <= alias_last) ? code + alias_ofs : code;
    return c - 1'b1;
  endfunction
endpackage

// File: rtl/prr_base_counter.sv
module prr_base_counter #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign nxt_o = cnt_q + 1'b1;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= nxt_o;
  end
endmodule

// File: rtl/prr_rate_decode.sv
module prr_rate_decode
  import prr_pkg::*;
#(
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned CNT_W      = 15,
  parameter int unsigned ALIAS_LAST = 2,
  parameter int unsigned ALIAS_OFS  = 7
) (
  input  logic [CODE_W-1:0] rate_i,
  input  logic              en_i,
  output logic              active_o,
  output logic [CNT_W-1:0]  mask_o
);
  logic [SHIFT_W-1:0] shift;

  assign active_o = en_i && (rate_i != '0);
  assign shift    = rate_shift(SHIFT_W'(rate_i), SHIFT_W'(ALIAS_LAST), SHIFT_W'(ALIAS_OFS));

  // Low 'shift' bits of the count must be zero for an event.
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask_o[i] = (SHIFT_W'(i) < shift);
  end
endmodule

// File: rtl/prr_event_gen.sv
module prr_event_gen #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] nxt_i,
  input  logic [CNT_W-1:0] mask_i,
  output logic             evt_o
);
  logic hit;

  assign hit = tick_i && active_i && ((nxt_i & mask_i) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_o <= 1'b0;
    else         evt_o <= hit;
  end
endmodule

// File: rtl/prr_rate_gen.sv
module prr_rate_gen #(
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned CNT_W      = 15,
  parameter int unsigned ALIAS_LAST = 2,
  parameter int unsigned ALIAS_OFS  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] rate_i,
  input  logic              en_i,
  output logic              evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] mask;
  logic             active;

  prr_base_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .cnt_o  (cnt_q),
    .nxt_o  (cnt_nxt)
  );

  prr_rate_decode #(
    .CODE_W     (CODE_W),
    .CNT_W      (CNT_W),
    .ALIAS_LAST (ALIAS_LAST),
    .ALIAS_OFS  (ALIAS_OFS)
  ) u_dec (
    .rate_i   (rate_i),
    .en_i     (en_i),
    .active_o (active),
    .mask_o   (mask)
  );

  prr_event_gen #(.CNT_W(CNT_W)) u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .active_i (active),
    .nxt_i    (cnt_nxt),
    .mask_i   (mask),
    .evt_o    (evt_o)
  );
endmodule

// File: rtl/prr_rate_gen_chk.sv
module prr_rate_gen_chk
  import prr_pkg::*;
#(
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned CNT_W      = 15,
  parameter int unsigned ALIAS_LAST = 2,
  parameter int unsigned ALIAS_OFS  = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [CODE_W-1:0] rate_i,
  input logic              en_i,
  input logic              evt_o,
  input logic [CNT_W-1:0]  cnt_i
);
  logic [CODE_W-1:0]  rate_q;
  logic [SHIFT_W-1:0] sh_q;
  logic [CNT_W-1:0]   low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rate_q <= '0;
    else         rate_q <= rate_i;
  end

  assign sh_q = rate_shift(SHIFT_W'(rate_q), SHIFT_W'(ALIAS_LAST), SHIFT_W'(ALIAS_OFS));

  always_comb begin
    for (int i = 0; i < CNT_W; i++) low_q[i] = (i < int'(sh_q)) ? cnt_i[i] : 1'b0;
  end

  a_r2_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> $past(tick_i));
  a_r2_one_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
  a_r3_code_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> ($past(rate_i) != '0));
  a_r4_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> $past(en_i));
  a_r4_count_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (cnt_i == CNT_W'($past(cnt_i) + 1'b1)));
  a_r4_count_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_i));
  a_r7_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (low_q == '0));
endmodule

bind prr_rate_gen prr_rate_gen_chk #(
  .CODE_W     (CODE_W),
  .CNT_W      (CNT_W),
  .ALIAS_LAST (ALIAS_LAST),
  .ALIAS_OFS  (ALIAS_OFS)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .rate_i (rate_i),
  .en_i   (en_i),
  .evt_o  (evt_o),
  .cnt_i  (cnt_q)
);

// File: tb/tb_prr_rate_gen.sv
`timescale 1ns/1ps
module tb_prr_rate_gen;
  localparam int unsigned WRAP = 32768;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       tick_i;
  logic [3:0] rate_i;
  logic       en_i;
  logic       evt_o;

  int unsigned mcnt;
  int          n_vec;
  int          n_bad;
  int unsigned seed;

  always #2.5 clk_i = ~clk_i;

  prr_rate_gen dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .rate_i (rate_i),
    .en_i   (en_i),
    .evt_o  (evt_o)
  );

  function automatic int unsigned period_of(input int unsigned code);
    int unsigned c;
    c = (code <= 2) ? code + 7 : code;
    return 32'd1 << (c - 1);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: evt_o=%0b expected %0b (count %0d)", tag, act, exp, mcnt);
    end
  endtask

  // Called at a falling edge: drive, advance the model, check after the next edge.
  task automatic step(input logic t, input logic [3:0] r, input logic e, input string tag);
    logic exp;
    tick_i = t; rate_i = r; en_i = e;
    exp = 1'b0;
    if (t) begin
      mcnt = (mcnt + 1) % WRAP;
      exp  = e && (r != 0) && ((mcnt % period_of(r)) == 0);
    end
    @(negedge clk_i);
    check(tag, evt_o, exp);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finish_run();
  end

  initial begin
    n_vec = 0; n_bad = 0; mcnt = 0; seed = 32'd1234;
    rst_ni = 1'b0; tick_i = 1'b0; rate_i = 4'd0; en_i = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R1", evt_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", evt_o, 1'b0);

    // R1: first event after the fourth tick with code 3
    for (int i = 0; i < 8; i++) step(1'b1, 4'd3, 1'b1, "R1");
    // R2: idle cycles between ticks never pulse
    for (int i = 0; i < 40; i++) step(i[0], 4'd3, 1'b1, "R2");
    // R5: every direct code
    for (int c = 3; c <= 15; c++)
      for (int i = 0; i < int'(2 * period_of(c)) + 3; i++) step(1'b1, 4'(c), 1'b1, "R5");
    // R6: aliased codes
    for (int c = 1; c <= 2; c++)
      for (int i = 0; i < 600; i++) step(1'b1, 4'(c), 1'b1, "R6");
    // R3: code zero
    for (int i = 0; i < 300; i++) step(1'b1, 4'd0, 1'b1, "R3");
    // R4: disabled, counter keeps running
    for (int i = 0; i < 203; i++) step(1'b1, 4'd3, 1'b0, "R4");
    // R7: re-enable at an odd offset, events stay on count boundaries
    for (int i = 0; i < 300; i++) step(1'b1, 4'd4, 1'b1, "R7");
    // R9: run to the wrap of the count
    while (mcnt != WRAP - 1) step(1'b1, 4'd15, 1'b1, "R9");
    step(1'b1, 4'd15, 1'b1, "R9");
    step(1'b1, 4'd3, 1'b1, "R9");
    // R8: random code and enable changes, dense ticks
    for (int i = 0; i < 20000; i++)
      step(($urandom(seed) % 4) != 0, 4'($urandom(seed)), ($urandom(seed) % 8) != 0, "R8");
    // R2: sparse random ticks
    for (int i = 0; i < 30000; i++)
      step(($urandom(seed) % 5) == 0, 4'($urandom(seed) % 6 + 1), 1'b1, "R2");
    finish_run();
  end
endmodule